// File: doc/BRIEF.md
# Fractional-Divider UART

This block is an asynchronous serial transmitter and receiver with a fractional baud divider. A prescaler reduces the system clock by 1, 2, 4 or 8. Each bit then lasts a number of prescaled ticks taken from a 13.3 fixed-point divider. Bits alternate between the integer count and one tick more, so the average bit time equals the programmed value.

The frame setup comes in as plain input ports: 7 or 8 data bits, one of four parity kinds or none, and one or two stop bits. Characters to send go into a four-entry transmit FIFO through a write strobe. Received characters wait in a four-entry receive FIFO that is read from its head. The receiver reports a fill count and three sticky error flags, and an interrupt line combines the sources selected by a mask.

Top module: `fracuart_top`

## Requirements
- R1: While reset is asserted, txd is 1, rx_level is 0, err_flags is 000, tx_full is 0 and irq is 0 with irq_en = 011.
- R2: A bit lasts div_val[15:3] prescaled ticks, plus one tick for each bit where a 3-bit accumulator that adds div_val[2:0] at every bit end carries out. The accumulator clears at frame start, so with 8.5 a start bit followed by eight zero data bits holds txd low for 76 clocks.
- R3: clk_sel = 0/1/2/3 gives one prescaled tick every 1/2/4/8 system clocks.
- R4: A frame is a 0 start bit, the data LSB first (8 bits when data8 = 1, else 7 bits with tx_data[7] ignored and rx_data[7] read as 0), an optional parity bit, and one stop bit (two when two_stop = 1) at 1. txd looped to rxd returns the character unchanged.
- R5: par_mode encodes 0 none, 1 odd, 2 even, 3 mark (always 1), 4 space (always 0). A received parity bit that does not match sets err_flags[0], and the character is still stored.
- R6: The transmit FIFO holds 4 characters. tx_full is 1 when it holds 4, and a write while full is dropped.
- R7: The receive FIFO holds 4 characters. rx_level gives their number, rx_data shows the oldest, and an rx_rd pulse removes it. rx_level changes by at most 1 per cycle.
- R8: A character that completes while the receive FIFO is full and rx_rd is low is discarded and sets err_flags[2].
- R9: A stop bit sampled as 0 (either stop bit when two are configured) sets err_flags[1].
- R10: A falling edge on rxd that reads high again at mid-bit is dropped as a false start. It stores nothing and raises no flag.
- R11: Error flags stay set until err_clr is high. When a flag is set and cleared in the same cycle, setting wins.
- R12: irq is the OR over irq_en of: bit 0 receive FIFO not empty, bit 1 any error flag set, bit 2 transmit FIFO empty. irq is 0 when irq_en is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 2 | Prescale select: divide by 1, 2, 4, 8 |
| div_val | input | 16 | Bit-time divider, 13 integer and 3 fraction bits |
| data8 | input | 1 | 1 = 8 data bits, 0 = 7 |
| par_mode | input | 3 | Parity kind (R5 encoding) |
| two_stop | input | 1 | 1 = two stop bits |
| tx_wr | input | 1 | Write strobe for the transmit FIFO |
| tx_data | input | 8 | Character to send |
| tx_full | output | 1 | Transmit FIFO full |
| rx_rd | input | 1 | Pop strobe for the receive FIFO |
| rx_data | output | 8 | Oldest received character |
| rx_level | output | 3 | Characters waiting in the receive FIFO |
| err_flags | output | 3 | Sticky flags: 0 parity, 1 framing, 2 overrun |
| err_clr | input | 1 | Clears all error flags |
| irq_en | input | 3 | Interrupt source mask |
| irq | output | 1 | Interrupt request |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
A receive error can be raised in the same cycle that software clears the flags. The bench holds err_clr high for the whole of a frame whose parity bit is wrong, so the completion cycle is sure to coincide with a clear. It then samples every cycle and requires the parity flag to be seen high for exactly one cycle, which shows the new error won over the clear. Overrun is tested with a burst of six writes: the transmit FIFO drops the sixth and the receive FIFO drops the fifth, and the order of the four stored characters is checked.

// File: rtl/fracuart_pkg.sv
package fracuart_pkg;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_ODD   = 3'd1,
    PAR_EVEN  = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } par_e;

  localparam int FRAME_MAX = 12;
  localparam int ERR_PAR   = 0;
  localparam int ERR_FRM   = 1;
  localparam int ERR_OVR   = 2;

  function automatic logic par_on(par_e m);
    return (m == PAR_ODD) || (m == PAR_EVEN) || (m == PAR_MARK) || (m == PAR_SPACE);
  endfunction

  function automatic logic calc_par(logic [7:0] d, logic d8, par_e m);
    logic x;
    x = ^(d & {d8, 7'h7F});
    case (m)
      PAR_ODD:  return ~x;
      PAR_EVEN: return x;
      PAR_MARK: return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] frame_bits(logic d8, par_e m, logic two);
    return 4'd9 + 4'(d8) + 4'(par_on(m)) + 4'(two);
  endfunction

  function automatic logic [FRAME_MAX-1:0] build_frame(logic [7:0] d, logic d8, par_e m, logic two);
    logic [FRAME_MAX-1:0] f;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < 7 || d8) f[i+1] = d[i];
    if (par_on(m)) f[d8 ? 9 : 8] = calc_par(d, d8, m);
    if (!two) f[FRAME_MAX-1] = 1'b1;
    return f;
  endfunction

endpackage

// File: rtl/fracuart_bittmr.sv
module fracuart_bittmr #(
  parameter int INT_W  = 13,
  parameter int FRAC_W = 3,
  parameter bit AT_MID = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              restart,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              strobe
);
  localparam int CW = INT_W + 1;

  logic [CW-1:0]     cnt_q, cnt_d, len;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic              ext_q, ext_d;
  logic              wrap;

  assign len  = {1'b0, div_int} + CW'(ext_q);
  assign wrap = ce & ~restart & (cnt_q == len - CW'(1));

  generate
    if (AT_MID) begin : g_mid
      assign strobe = ce & ~restart & (cnt_q == (len >> 1));
    end else begin : g_end
      assign strobe = wrap;
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    acc_d = acc_q;
    ext_d = ext_q;
    if (restart) begin
      cnt_d = '0;
      acc_d = '0;
      ext_d = 1'b0;
    end else if (ce) begin
      if (wrap) begin
        cnt_d = '0;
        {ext_d, acc_d} = {1'b0, acc_q} + {1'b0, div_frac};
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
      ext_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
      ext_q <= ext_d;
    end
  end
endmodule

// File: rtl/fracuart_fifo.sv
module fracuart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [LW-1:0] cnt_q;
  logic          full, empty, wr_ok, rd_ok;

  assign full  = (cnt_q == LW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign wr_ok = push & (~full | pop);
  assign rd_ok = pop & ~empty;
  assign dout  = mem_q[rd_q];
  assign level = cnt_q;

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + AW'(1);
      if (rd_ok) rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + AW'(1);
      cnt_q <= cnt_q + LW'(wr_ok) - LW'(rd_ok);
    end
  end
endmodule

// File: rtl/fracuart_tx.sv
module fracuart_tx
  import fracuart_pkg::*;
#(
  parameter int INT_W  = 13,
  parameter int FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  input  logic              d8,
  input  par_e              pmode,
  input  logic              two_stop,
  input  logic              q_empty,
  input  logic [7:0]        q_data,
  output logic              q_pop,
  output logic              txd
);
  logic                 busy_q, busy_d, load, bit_end;
  logic [FRAME_MAX-1:0] sh_q, sh_d;
  logic [3:0]           left_q, left_d;

  assign load  = ~busy_q & ~q_empty;
  assign q_pop = load;
  assign txd   = sh_q[0];

  fracuart_bittmr #(.INT_W(INT_W), .FRAC_W(FRAC_W), .AT_MID(1'b0)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ce(ce), .restart(load),
    .div_int(div_int), .div_frac(div_frac), .strobe(bit_end)
  );

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    left_d = left_q;
    if (load) begin
      sh_d   = build_frame(q_data, d8, pmode, two_stop);
      left_d = frame_bits(d8, pmode, two_stop);
      busy_d = 1'b1;
    end else if (busy_q && bit_end) begin
      sh_d   = {1'b1, sh_q[FRAME_MAX-1:1]};
      left_d = left_q - 4'd1;
      busy_d = (left_q != 4'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/fracuart_rx.sv
module fracuart_rx
  import fracuart_pkg::*;
#(
  parameter int INT_W  = 13,
  parameter int FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  input  logic              d8,
  input  par_e              pmode,
  input  logic              two_stop,
  input  logic              rxd,
  output logic              done,
  output logic [7:0]        data,
  output logic              par_err,
  output logic              frm_err
);
  logic                 s1_q, s2_q, run_q, run_d;
  logic                 fall, restart, mid, false_start, last;
  logic [3:0]           idx_q, idx_d, ppos, spos;
  logic [FRAME_MAX-1:0] samp_q, samp_d, samp_n;

  assign fall    = ~s1_q & s2_q;
  assign restart = ~run_q & fall;

  fracuart_bittmr #(.INT_W(INT_W), .FRAC_W(FRAC_W), .AT_MID(1'b1)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ce(ce), .restart(restart),
    .div_int(div_int), .div_frac(div_frac), .strobe(mid)
  );

  always_comb begin
    samp_n         = samp_q;
    samp_n[idx_q]  = s1_q;
    last           = (idx_q == frame_bits(d8, pmode, two_stop) - 4'd1);
    false_start    = (idx_q == 4'd0) & s1_q;
    done           = run_q & mid & ~false_start & last;
    for (int i = 0; i < 8; i++)
      data[i] = (i < 7 || d8) ? samp_n[i+1] : 1'b0;
    ppos    = d8 ? 4'd9 : 4'd8;
    spos    = ppos + 4'(par_on(pmode));
    par_err = par_on(pmode) & (samp_n[ppos] != calc_par(data, d8, pmode));
    frm_err = ~samp_n[spos] | (two_stop & ~samp_n[spos + 4'd1]);
  end

  always_comb begin
    run_d  = run_q;
    idx_d  = idx_q;
    samp_d = samp_q;
    if (restart) begin
      run_d = 1'b1;
      idx_d = 4'd0;
    end else if (run_q && mid) begin
      if (false_start) begin
        run_d = 1'b0;
      end else begin
        samp_d = samp_n;
        idx_d  = idx_q + 4'd1;
        if (last) run_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      run_q  <= 1'b0;
      idx_q  <= '0;
      samp_q <= '1;
    end else begin
      s1_q   <= rxd;
      s2_q   <= s1_q;
      run_q  <= run_d;
      idx_q  <= idx_d;
      samp_q <= samp_d;
    end
  end
endmodule

// File: rtl/fracuart_top.sv
module fracuart_top
  import fracuart_pkg::*;
#(
  parameter int DIV_INT_W  = 13,
  parameter int DIV_FRAC_W = 3,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [1:0]                      clk_sel,
  input  logic [DIV_INT_W+DIV_FRAC_W-1:0] div_val,
  input  logic                            data8,
  input  logic [2:0]                      par_mode,
  input  logic                            two_stop,
  input  logic                            tx_wr,
  input  logic [7:0]                      tx_data,
  output logic                            tx_full,
  input  logic                            rx_rd,
  output logic [7:0]                      rx_data,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] rx_level,
  output logic [2:0]                      err_flags,
  input  logic                            err_clr,
  input  logic [2:0]                      irq_en,
  output logic                            irq,
  input  logic                            rxd,
  output logic                            txd
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  logic [1:0]            rst_sync_q;
  logic                  rst_int_n;
  logic [2:0]            ps_q, ps_mask;
  logic                  ce;
  par_e                  pmode;
  logic [DIV_INT_W-1:0]  div_int;
  logic [DIV_FRAC_W-1:0] div_frac;
  logic [LVL_W-1:0]      tx_level;
  logic [7:0]            tq_data, rx_char;
  logic                  tx_pop, tx_empty, rx_full;
  logic                  rx_done, rx_perr, rx_ferr;
  logic [2:0]            err_q, err_d, err_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign pmode    = par_e'(par_mode);
  assign div_int  = div_val[DIV_INT_W+DIV_FRAC_W-1:DIV_FRAC_W];
  assign div_frac = div_val[DIV_FRAC_W-1:0];

  always_comb begin
    case (clk_sel)
      2'd0:    ps_mask = 3'b000;
      2'd1:    ps_mask = 3'b001;
      2'd2:    ps_mask = 3'b011;
      default: ps_mask = 3'b111;
    endcase
  end
  assign ce = ((ps_q & ps_mask) == 3'b000);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ps_q <= '0;
    else            ps_q <= ps_q + 3'd1;
  end

  fracuart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_int_n), .push(tx_wr), .din(tx_data),
    .pop(tx_pop), .dout(tq_data), .level(tx_level)
  );
  assign tx_full  = (tx_level == LVL_W'(FIFO_DEPTH));
  assign tx_empty = (tx_level == '0);

  fracuart_tx #(.INT_W(DIV_INT_W), .FRAC_W(DIV_FRAC_W)) u_tx (
    .clk(clk), .rst_n(rst_int_n), .ce(ce), .div_int(div_int), .div_frac(div_frac),
    .d8(data8), .pmode(pmode), .two_stop(two_stop),
    .q_empty(tx_empty), .q_data(tq_data), .q_pop(tx_pop), .txd(txd)
  );

  fracuart_rx #(.INT_W(DIV_INT_W), .FRAC_W(DIV_FRAC_W)) u_rx (
    .clk(clk), .rst_n(rst_int_n), .ce(ce), .div_int(div_int), .div_frac(div_frac),
    .d8(data8), .pmode(pmode), .two_stop(two_stop), .rxd(rxd),
    .done(rx_done), .data(rx_char), .par_err(rx_perr), .frm_err(rx_ferr)
  );

  fracuart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_int_n), .push(rx_done), .din(rx_char),
    .pop(rx_rd), .dout(rx_data), .level(rx_level)
  );
  assign rx_full = (rx_level == LVL_W'(FIFO_DEPTH));

  always_comb begin
    err_set          = '0;
    err_set[ERR_PAR] = rx_done & rx_perr;
    err_set[ERR_FRM] = rx_done & rx_ferr;
    err_set[ERR_OVR] = rx_done & rx_full & ~rx_rd;
    err_d            = (err_q & ~{3{err_clr}}) | err_set;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) err_q <= '0;
    else            err_q <= err_d;
  end

  assign err_flags = err_q;
  assign irq       = |(irq_en & {tx_empty, |err_q, (rx_level != '0)});
endmodule

// File: rtl/fracuart_chk.sv
module fracuart_chk #(
  parameter int FIFO_DEPTH = 4
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] rx_level,
  input logic [2:0]                      err_flags,
  input logic                            err_clr,
  input logic [2:0]                      irq_en,
  input logic                            irq
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  assert_rx_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LVL_W'(FIFO_DEPTH));

  assert_rx_level_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == $past(rx_level)) || (rx_level == $past(rx_level) + LVL_W'(1)) ||
    (rx_level + LVL_W'(1) == $past(rx_level)));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(err_clr) |-> ((err_flags & $past(err_flags)) == $past(err_flags)));

  assert_overrun_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[2]) |-> ($past(rx_level) == LVL_W'(FIFO_DEPTH)));

  assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 3'b000) |-> !irq);
endmodule

bind fracuart_top fracuart_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .err_flags(err_flags),
  .err_clr(err_clr), .irq_en(irq_en), .irq(irq)
);

// File: tb/fracuart_top_test.sv
module fracuart_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] clk_sel;
  logic [15:0] div_val;
  logic       data8, two_stop, tx_wr, rx_rd, err_clr, loop_en, drv_rxd;
  logic [2:0] par_mode, irq_en, err_flags;
  logic [7:0] tx_data, rx_data;
  logic [2:0] rx_level;
  logic       tx_full, irq, txd, rxd;

  int nchk = 0;
  int nfail = 0;
  logic mon = 1'b0;
  int seen = 0;

  always #10 clk = ~clk;
  assign rxd = loop_en ? txd : drv_rxd;

  fracuart_top uut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .div_val(div_val), .data8(data8),
    .par_mode(par_mode), .two_stop(two_stop), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_full(tx_full), .rx_rd(rx_rd), .rx_data(rx_data), .rx_level(rx_level),
    .err_flags(err_flags), .err_clr(err_clr), .irq_en(irq_en), .irq(irq),
    .rxd(rxd), .txd(txd)
  );

  // {data8, par_mode, two_stop, sent, expected}
  localparam logic [20:0] VECS [7] = '{
    {1'b0, 3'd1, 1'b1, 8'h45, 8'h45},
    {1'b1, 3'd0, 1'b0, 8'hA5, 8'hA5},
    {1'b1, 3'd2, 1'b1, 8'h3C, 8'h3C},
    {1'b0, 3'd3, 1'b0, 8'hC5, 8'h45},
    {1'b1, 3'd4, 1'b1, 8'hFF, 8'hFF},
    {1'b0, 3'd2, 1'b0, 8'h00, 8'h00},
    {1'b1, 3'd1, 1'b0, 8'h80, 8'h80}
  };

  always @(negedge clk) if (mon && err_flags[0]) seen++;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    nchk++;
    if (act < lo || act > hi) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic send_tx(input logic [7:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_data = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic wait_rx(input int n);
    for (int k = 0; k < 3000 && rx_level != 3'(n); k++) @(negedge clk);
  endtask

  task automatic pop_rx();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic drive_bits(input logic [11:0] bits, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); drv_rxd = bits[k];
      repeat (7) @(negedge clk);
    end
    @(negedge clk); drv_rxd = 1'b1;
    repeat (30) @(negedge clk);
  endtask

  task automatic low_time(output int cnt);
    cnt = 0;
    for (int k = 0; k < 2000 && txd !== 1'b0; k++) @(negedge clk);
    while (txd === 1'b0 && cnt < 5000) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int t;
    rst_n = 1'b0; clk_sel = 2'd0; div_val = 16'd64; data8 = 1'b1; par_mode = 3'd0;
    two_stop = 1'b0; tx_wr = 1'b0; tx_data = 8'h00; rx_rd = 1'b0; err_clr = 1'b0;
    irq_en = 3'b011; loop_en = 1'b1; drv_rxd = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 txd", 32'(txd), 1);
    chk("R1 rx_level", 32'(rx_level), 0);
    chk("R1 err_flags", 32'(err_flags), 0);
    chk("R1 tx_full", 32'(tx_full), 0);
    chk("R1 irq", 32'(irq), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Table walk: loopback frames in every format (R4, R5)
    for (int i = 0; i < 7; i++) begin
      data8 = VECS[i][20]; par_mode = VECS[i][19:17]; two_stop = VECS[i][16];
      send_tx(VECS[i][15:8]);
      wait_rx(1);
      chk("R4 loopback data", 32'(rx_data), 32'(VECS[i][7:0]));
      chk("R5 no error flags", 32'(err_flags), 0);
      pop_rx();
      repeat (20) @(negedge clk);
    end

    // R2: fractional divider 8.5 and integer 8.0
    data8 = 1'b1; par_mode = 3'd0; two_stop = 1'b0;
    div_val = {13'd8, 3'd4};
    send_tx(8'h00); low_time(t);
    chk("R2 low time at 8.5", 32'(t), 76);
    wait_rx(1);
    chk("R2 loopback at 8.5", 32'(rx_data), 0);
    pop_rx(); repeat (20) @(negedge clk);
    div_val = {13'd8, 3'd0};
    send_tx(8'h00); low_time(t);
    chk("R2 low time at 8.0", 32'(t), 72);
    wait_rx(1); pop_rx(); repeat (20) @(negedge clk);
    div_val = {13'd13, 3'd3};
    send_tx(8'h5A); wait_rx(1);
    chk("R2 loopback at 13.375", 32'(rx_data), 32'h5A);
    pop_rx(); repeat (30) @(negedge clk);

    // R3: prescale by 4
    div_val = {13'd8, 3'd0}; clk_sel = 2'd2;
    send_tx(8'h00); low_time(t);
    chk_rng("R3 low time with divide by 4", t, 285, 288);
    wait_rx(1);
    chk("R3 loopback with divide by 4", 32'(rx_data), 0);
    pop_rx(); repeat (60) @(negedge clk);
    clk_sel = 2'd0;

    // R6, R7, R8: burst of six writes
    @(negedge clk);
    for (int k = 1; k <= 5; k++) begin
      tx_wr = 1'b1; tx_data = 8'(k * 17);
      @(negedge clk);
    end
    chk("R6 tx_full after burst", 32'(tx_full), 1);
    tx_data = 8'h66; @(negedge clk); tx_wr = 1'b0;
    repeat (700) @(negedge clk);
    chk("R7 rx_level full", 32'(rx_level), 4);
    chk("R8 overrun flag", 32'(err_flags), 32'b100);
    for (int k = 1; k <= 4; k++) begin
      chk("R7 oldest first", 32'(rx_data), 32'(8'(k * 17)));
      pop_rx();
    end
    repeat (200) @(negedge clk);
    chk("R6 dropped write never sent", 32'(rx_level), 0);
    clear_err();
    chk("R11 clear", 32'(err_flags), 0);

    // R10: false start, then a good manual frame
    loop_en = 1'b0;
    @(negedge clk); drv_rxd = 1'b0; repeat (2) @(negedge clk); drv_rxd = 1'b1;
    repeat (150) @(negedge clk);
    chk("R10 glitch stores nothing", 32'(rx_level), 0);
    chk("R10 glitch raises no flag", 32'(err_flags), 0);
    drive_bits({2'b11, 8'h3C, 1'b0}, 10);
    chk("R10 receiver recovers", 32'(rx_data), 32'h3C);
    pop_rx();

    // R5: even parity, wrong parity bit
    par_mode = 3'd2;
    drive_bits({1'b1, 1'b1, 1'b0, 8'h01, 1'b0}, 11);
    chk("R5 parity flag", 32'(err_flags), 32'b001);
    chk("R5 char kept", 32'(rx_data), 32'h01);
    irq_en = 3'b010; @(negedge clk);
    chk("R12 irq from error", 32'(irq), 1);
    irq_en = 3'b001; @(negedge clk);
    chk("R12 irq from rx data", 32'(irq), 1);
    pop_rx(); clear_err();
    irq_en = 3'b011; @(negedge clk);
    chk("R12 irq idle", 32'(irq), 0);
    irq_en = 3'b100; @(negedge clk);
    chk("R12 irq tx empty", 32'(irq), 1);
    irq_en = 3'b000;

    // R9: second stop bit low
    par_mode = 3'd0; two_stop = 1'b1;
    drive_bits({1'b1, 1'b0, 1'b1, 8'hA5, 1'b0}, 11);
    chk("R9 framing flag", 32'(err_flags), 32'b010);
    chk("R9 char kept", 32'(rx_data), 32'hA5);
    pop_rx(); clear_err();

    // R11: error set while clear is held
    two_stop = 1'b0; par_mode = 3'd2;
    @(negedge clk); err_clr = 1'b1; seen = 0; mon = 1'b1;
    drive_bits({1'b1, 1'b1, 1'b0, 8'h01, 1'b0}, 11);
    mon = 1'b0;
    chk("R11 set wins over clear", 32'(seen), 1);
    err_clr = 1'b0; @(negedge clk);
    chk("R11 flags cleared", 32'(err_flags), 0);
    pop_rx(); @(negedge clk);
    chk("R7 empty at end", 32'(rx_level), 0);

    summary();
    $finish;
  end
endmodule